// File: doc/BRIEF.md
# Ring-Bus Polling Host Controller

This block masters a serpentine byte bus that links up to sixteen peripheral slots. The controller drives one strobe per slot, a write flag, an address-tag flag and an 8-bit register address. The data byte it sends passes through every peripheral in turn and comes back on the return input. A peripheral ends a beat by raising acknowledge, and it may raise stall to stretch the beat for as long as it needs.

A host-side command port accepts one request at a time: target slot, starting register, byte count, direction and address-increment choice. Write bytes come from the host one per acknowledged beat, and read bytes go back as single-cycle pulses. A burst stops at the first beat that is not acknowledged, and the completion pulse reports how many bytes were actually moved. This lets FIFO-backed registers take or give only what they can.

When no request is waiting, the controller polls the slots in round-robin order with the tag low. A peripheral that answers a poll with a non-zero byte gets that many registers read from address zero upward. Those bytes go out as an unsolicited upload, marked as such.

Top module: `rb_host_ctrl`

## Requirements
- R1: A register cycle drives `bus_tag`=1, with `bus_we`=1 for writes and 0 for reads. A poll drives `bus_tag`=0, `bus_we`=0 and `bus_adr`=0. At most one bit of `bus_stb` is high, and that bit is the index of the addressed slot.
- R2: With `req_inc`=1 the beats of a request use the addresses `req_addr`, `req_addr`+1, and so on. With `req_inc`=0 every beat uses `req_addr`.
- R3: A write burst ends at the first beat that is not acknowledged. The `done_count` value gives the number of acknowledged bytes, and each of those bytes appeared on `bus_dout` during its beat.
- R4: Each acknowledged read beat produces a one-cycle `rd_valid` pulse in the cycle after the acknowledge, carrying the `bus_din` value sampled on that acknowledge edge. A read burst also stops at the first unacknowledged beat.
- R5: While `bus_stall` is high, the strobe, address, direction and tag hold steady, no beat completes, and the no-acknowledge timeout does not run.
- R6: A strobe that stays high for 16 consecutive clocks with neither acknowledge nor stall ends the beat as unacknowledged. The strobe is then dropped.
- R7: When idle, the controller polls one slot at a time. Each new poll targets the slot after the previous poll, modulo the slot count.
- R8: A non-zero poll answer N starts reads of registers 0 to N-1 of that slot, with `rd_auto`=1 on those bytes. The upload ends with `done`=1, `done_auto`=1, `done_slot` set to the slot and `done_count` set to the number of bytes read.
- R9: `req_ready` is high only when no bus cycle is in progress. A request waits until the current poll or upload has finished, and it takes priority over the next poll.
- R10: A request with count 0 produces `done`=1 with `done_count`=0 in the next cycle and drives no strobe.
- R11: After reset no strobe is high, `done` and `rd_valid` are low, and `req_ready` is high.
- R12: `wr_take` is high for one cycle per acknowledged host write byte. This tells the host to present the next byte on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock when high together with `req_valid` |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_slot | input | 4 | Target peripheral slot |
| req_addr | input | 8 | First register address |
| req_count | input | 8 | Number of bytes to transfer |
| req_inc | input | 1 | 1 = increment address per beat |
| wr_data | input | 8 | Byte to write in the current beat |
| wr_take | output | 1 | Current write byte was accepted |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| rd_auto | output | 1 | Read byte belongs to an unsolicited upload |
| done | output | 1 | Request or upload finished |
| done_auto | output | 1 | Finished transfer was an upload |
| done_slot | output | 4 | Slot of the finished transfer |
| done_count | output | 8 | Bytes transferred |
| bus_stb | output | 16 | Per-slot cycle strobes |
| bus_we | output | 1 | Bus write flag |
| bus_tag | output | 1 | 1 = register cycle, 0 = poll |
| bus_adr | output | 8 | Register address |
| bus_dout | output | 8 | Data byte entering the ring |
| bus_din | input | 8 | Data byte returning from the ring |
| bus_stall | input | 1 | Peripheral needs more clocks |
| bus_ack | input | 1 | Peripheral completed the beat |

## Verification
The bench models six present slots and ten absent ones. Bursts are swept over lengths and slots, so an address that failed to step, or stepped when it should have held, shows up as wrong logged addresses or wrong read bytes. FIFO registers refuse bytes after a set limit. A controller that ignored a missing acknowledge would report the full request count rather than the accepted count. A stall that outlasts the timeout must still end in a completed beat with a 21-clock strobe; a design that let the timeout run during stall would report zero bytes. Absent slots must give a strobe of exactly 16 clocks and a count of zero. A poll answer of three must yield three uploaded bytes from register zero on the answering slot. A zero-length request must finish without any strobe.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int RB_DW = 8;   // ring data width
    localparam int RB_AW = 8;   // register address width

    typedef enum logic {
        ST_IDLE,
        ST_BEAT
    } rb_state_t;

    typedef enum logic [1:0] {
        MD_HOST,
        MD_POLL,
        MD_AUTO
    } rb_mode_t;

    // Per-burst cycle descriptor
    typedef struct packed {
        logic [RB_AW-1:0] adr;
        logic             we;
        logic             inc;
    } rb_cyc_t;

    function automatic logic [RB_AW-1:0] rb_step(input logic [RB_AW-1:0] a, input logic inc);
        return a + {{(RB_AW-1){1'b0}}, inc};
    endfunction
endpackage

// File: rtl/rb_strobe_dec.sv
module rb_strobe_dec #(
    parameter int NSLOT = 16,
    parameter int SW    = 4
) (
    input  logic             en,
    input  logic [SW-1:0]    sel,
    output logic [NSLOT-1:0] stb
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_stb
        assign stb[i] = en && (sel == SW'(i));
    end
endmodule

// File: rtl/rb_rr_ptr.sv
module rb_rr_ptr #(
    parameter int NSLOT = 16,
    parameter int SW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [SW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == SW'(NSLOT-1)) ? '0 : ptr + 1'b1;
    end

    // R7: the poll pointer wraps to slot zero after the last slot
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == SW'(NSLOT-1)) |=> (ptr == '0));
endmodule

// File: rtl/rb_ack_timer.sv
module rb_ack_timer #(
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    output logic expire
);
    localparam int TW = $clog2(TMO + 1);
    logic [TW-1:0] cnt;

    assign expire = run && !hold && (cnt == TW'(TMO-1));

    always_ff @(posedge clk) begin
        if (rst || !run || hold || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R6: the wait counter never passes the timeout window
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < TW'(TMO));
endmodule

// File: rtl/rb_host_ctrl.sv
module rb_host_ctrl
    import rb_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int TMO   = 16,
    localparam int SW   = $clog2(NSLOT),
    localparam int CW   = RB_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [SW-1:0]    req_slot,
    input  logic [RB_AW-1:0] req_addr,
    input  logic [CW-1:0]    req_count,
    input  logic             req_inc,
    input  logic [RB_DW-1:0] wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [RB_DW-1:0] rd_data,
    output logic             rd_auto,
    output logic             done,
    output logic             done_auto,
    output logic [SW-1:0]    done_slot,
    output logic [CW-1:0]    done_count,
    output logic [NSLOT-1:0] bus_stb,
    output logic             bus_we,
    output logic             bus_tag,
    output logic [RB_AW-1:0] bus_adr,
    output logic [RB_DW-1:0] bus_dout,
    input  logic [RB_DW-1:0] bus_din,
    input  logic             bus_stall,
    input  logic             bus_ack
);
    rb_state_t       st;
    rb_mode_t        md;
    rb_cyc_t         cyc;
    logic [SW-1:0]   cur_slot;
    logic [CW-1:0]   left;
    logic [CW-1:0]   got;
    logic [SW-1:0]   poll_ptr;
    logic            busy, beat_ok, miss, poll_adv, last_beat;

    assign busy      = (st == ST_BEAT);
    assign beat_ok   = busy && bus_ack && !bus_stall;
    assign last_beat = (left == CW'(1));

    rb_ack_timer #(.TMO(TMO)) u_tmr (
        .clk(clk), .rst(rst), .run(busy), .hold(bus_stall || beat_ok), .expire(miss)
    );

    rb_strobe_dec #(.NSLOT(NSLOT), .SW(SW)) u_dec (
        .en(busy), .sel(cur_slot), .stb(bus_stb)
    );

    assign poll_adv = busy &&
        (((md == MD_POLL) && (miss || (beat_ok && bus_din == '0))) ||
         ((md == MD_AUTO) && (miss || (beat_ok && last_beat))));

    rb_rr_ptr #(.NSLOT(NSLOT), .SW(SW)) u_ptr (
        .clk(clk), .rst(rst), .adv(poll_adv), .ptr(poll_ptr)
    );

    assign req_ready = (st == ST_IDLE);
    assign bus_tag   = (md != MD_POLL);
    assign bus_we    = busy && cyc.we;
    assign bus_adr   = busy ? cyc.adr : '0;
    assign bus_dout  = (busy && cyc.we) ? wr_data : '0;
    assign wr_take   = beat_ok && cyc.we && (md == MD_HOST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            md         <= MD_POLL;
            cyc        <= '0;
            cur_slot   <= '0;
            left       <= '0;
            got        <= '0;
            done       <= 1'b0;
            done_auto  <= 1'b0;
            done_slot  <= '0;
            done_count <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            rd_auto    <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_slot <= req_slot;
                        cyc      <= '{adr: req_addr, we: req_write, inc: req_inc};
                        left     <= req_count;
                        got      <= '0;
                        md       <= MD_HOST;
                        if (req_count == '0) begin
                            done       <= 1'b1;
                            done_auto  <= 1'b0;
                            done_slot  <= req_slot;
                            done_count <= '0;
                        end else begin
                            st <= ST_BEAT;
                        end
                    end else begin
                        cur_slot <= poll_ptr;
                        cyc      <= '0;
                        md       <= MD_POLL;
                        st       <= ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (md == MD_POLL) begin
                        if (beat_ok) begin
                            if (bus_din != '0) begin
                                md   <= MD_AUTO;
                                cyc  <= '{adr: '0, we: 1'b0, inc: 1'b1};
                                left <= bus_din;
                                got  <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (miss) begin
                            st <= ST_IDLE;
                        end
                    end else if (beat_ok) begin
                        got     <= got + 1'b1;
                        left    <= left - 1'b1;
                        cyc.adr <= rb_step(cyc.adr, cyc.inc);
                        if (!cyc.we) begin
                            rd_valid <= 1'b1;
                            rd_data  <= bus_din;
                            rd_auto  <= (md == MD_AUTO);
                        end
                        if (last_beat) begin
                            st         <= ST_IDLE;
                            done       <= 1'b1;
                            done_auto  <= (md == MD_AUTO);
                            done_slot  <= cur_slot;
                            done_count <= got + 1'b1;
                        end
                    end else if (miss) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        done_auto  <= (md == MD_AUTO);
                        done_slot  <= cur_slot;
                        done_count <= got;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: never more than one slot strobed
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_stb));
    // R1: polls are reads of address zero
    a_r1_poll_shape: assert property (@(posedge clk) disable iff (rst)
        (|bus_stb && !bus_tag) |-> (!bus_we && bus_adr == '0));
    // R5: a stalled beat keeps every bus control steady
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (|bus_stb && bus_stall) |=> ($stable(bus_stb) && $stable(bus_adr) &&
                                     $stable(bus_we) && $stable(bus_tag)));
    // R4: a read byte only follows an accepted read beat
    a_r4_rd_after_ack: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(|bus_stb && bus_ack && !bus_stall && !bus_we));
    // R12: the host is told to advance only on an accepted write beat
    a_r12_take_on_ack: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (bus_ack && !bus_stall && bus_we && |bus_stb));
    // R9: no request is taken while the bus is in use
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        |bus_stb |-> !req_ready);
    // R10: an empty request completes at once without a bus cycle
    a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_count == '0) |=> (done && !(|bus_stb)));
endmodule

// File: tb/tb_rb_host_ctrl.sv
module tb_rb_host_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_write, req_inc;
    logic [3:0] req_slot;
    logic [7:0] req_addr, req_count;
    logic [7:0] wr_data;
    logic       req_ready, wr_take, rd_valid, rd_auto, done, done_auto;
    logic [7:0] rd_data, done_count;
    logic [3:0] done_slot;
    logic [15:0] bus_stb;
    logic       bus_we, bus_tag, bus_stall, bus_ack;
    logic [7:0] bus_adr, bus_dout, bus_din;

    always #10 clk = ~clk;

    rb_host_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_slot(req_slot), .req_addr(req_addr),
        .req_count(req_count), .req_inc(req_inc), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_auto(rd_auto), .done(done),
        .done_auto(done_auto), .done_slot(done_slot), .done_count(done_count),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_tag(bus_tag), .bus_adr(bus_adr),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_stall(bus_stall), .bus_ack(bus_ack)
    );

    // Peripheral model configuration (driven by the main sequence)
    localparam logic [15:0] PRESENT = 16'h02AE;   // slots 1,2,3,5,7,9
    int         wr_lim, rd_lim, stall_len;
    logic [3:0] stall_slot, pend_slot;
    logic [7:0] pend_val;
    logic       pend_on;

    // Peripheral model state (driven by the model process)
    int wr_used, rd_used, stall_cnt, widx, wn, rn;
    int run_len, last_run, ord_n, ord_bad, r9_bad, p1_bad;
    logic [3:0] last_poll;
    logic       have_prev, prev_poll;
    logic [7:0] wlog_adr [64];
    logic [7:0] wlog_dat [64];
    logic [3:0] wlog_slot[64];
    logic [7:0] rlog     [64];
    logic       rlog_auto[64];

    logic [3:0] sel;
    logic       act, p_ack, p_stall;
    logic [7:0] p_din;

    always_comb begin
        sel = 4'd0;
        act = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (bus_stb[i]) begin
                sel = 4'(i);
                act = 1'b1;
            end
        end
        p_stall = act && (stall_len > 0) && (sel == stall_slot) && (stall_cnt < stall_len);
        p_ack = 1'b0;
        p_din = 8'h00;
        if (act && PRESENT[sel]) begin
            if (!bus_tag) begin
                p_ack = 1'b1;
                p_din = (pend_on && sel == pend_slot) ? pend_val : 8'h00;
            end else if (bus_adr[7]) begin
                if (bus_we) p_ack = (wr_used < wr_lim);
                else begin
                    p_ack = (rd_used < rd_lim);
                    p_din = 8'hA0 + rd_used[7:0];
                end
            end else begin
                p_ack = 1'b1;
                p_din = {sel, bus_adr[3:0]};
            end
        end
    end

    assign bus_ack   = p_ack;
    assign bus_stall = p_stall;
    assign bus_din   = p_din;
    assign wr_data   = 8'h30 + widx[7:0];

    logic poll_now;
    assign poll_now = act && !bus_tag;

    always @(posedge clk) begin
        if (rst) begin
            wr_used <= 0; rd_used <= 0; stall_cnt <= 0; widx <= 0; wn <= 0; rn <= 0;
            run_len <= 0; last_run <= 0; ord_n <= 0; ord_bad <= 0; r9_bad <= 0; p1_bad <= 0;
            last_poll <= 4'd0; have_prev <= 1'b0; prev_poll <= 1'b0;
        end else begin
            stall_cnt <= act ? stall_cnt + 1 : 0;
            if (act && p_ack && !p_stall && bus_tag) begin
                if (bus_we) begin
                    wlog_adr[wn & 63]  <= bus_adr;
                    wlog_dat[wn & 63]  <= bus_dout;
                    wlog_slot[wn & 63] <= sel;
                    wn <= wn + 1;
                    if (bus_adr[7]) wr_used <= wr_used + 1;
                end else if (bus_adr[7]) begin
                    rd_used <= rd_used + 1;
                end
            end
            if (wr_take) widx <= widx + 1;
            if (rd_valid) begin
                rlog[rn & 63]      <= rd_data;
                rlog_auto[rn & 63] <= rd_auto;
                rn <= rn + 1;
            end
            if (act) run_len <= run_len + 1;
            else if (run_len != 0) begin
                last_run <= run_len;
                run_len  <= 0;
            end
            if (poll_now && !prev_poll) begin
                if (have_prev && sel != last_poll + 4'd1) ord_bad <= ord_bad + 1;
                ord_n     <= ord_n + 1;
                last_poll <= sel;
                have_prev <= 1'b1;
            end
            prev_poll <= poll_now;
            if (act && req_ready) r9_bad <= r9_bad + 1;
            if (poll_now && (bus_we || bus_adr != 8'h00)) p1_bad <= p1_bad + 1;
        end
    end

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
        end
    endtask

    task automatic host_req(input bit we, input int slot, input int adr, input int cnt,
                            input bit inc, output int got);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = we; req_slot = 4'(slot);
        req_addr = 8'(adr); req_count = 8'(cnt); req_inc = inc;
        @(negedge clk);
        req_valid = 1'b0;
        while (!(done && !done_auto)) @(negedge clk);
        got = int'(done_count);
    endtask

    task automatic run_all();
        int got, w0, x0, r0, b0;
        // R11: reset state
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(bus_stb == 16'h0, "R11 strobe", int'(bus_stb), 0);
        chk(!done && !rd_valid, "R11 done/rd_valid", int'({done, rd_valid}), 0);
        chk(req_ready, "R11 req_ready", int'(req_ready), 1);

        // R10: zero-length request
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_slot = 4'd3; req_addr = 8'h05;
        req_count = 8'd0; req_inc = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && done_count == 8'd0, "R10 done", int'(done), 1);
        chk(bus_stb == 16'h0, "R10 no strobe", int'(bus_stb), 0);

        // R2/R3/R12: fixed-address writes to a plain register, lengths 1..4
        for (int n = 1; n <= 4; n++) begin
            w0 = wn; x0 = widx;
            host_req(1'b1, 9, 8'h10, n, 1'b0, got);
            chk(got == n, "R3 write count", got, n);
            chk(widx - x0 == n, "R12 take pulses", widx - x0, n);
            for (int k = 0; k < n; k++) begin
                chk(wlog_adr[(w0 + k) & 63] == 8'h10, "R2 fixed write addr",
                    int'(wlog_adr[(w0 + k) & 63]), 16);
                chk(wlog_dat[(w0 + k) & 63] == 8'(8'h30 + x0 + k), "R3 write data",
                    int'(wlog_dat[(w0 + k) & 63]), (8'h30 + x0 + k) & 255);
                chk(wlog_slot[(w0 + k) & 63] == 4'd9, "R1 write slot",
                    int'(wlog_slot[(w0 + k) & 63]), 9);
            end
        end

        // R2: incrementing write
        w0 = wn;
        host_req(1'b1, 3, 8'h20, 5, 1'b1, got);
        chk(got == 5, "R3 inc write count", got, 5);
        for (int k = 0; k < 5; k++)
            chk(wlog_adr[(w0 + k) & 63] == 8'(8'h20 + k), "R2 inc write addr",
                int'(wlog_adr[(w0 + k) & 63]), 32 + k);

        // R2/R4: incrementing reads swept over slots and lengths
        for (int s = 1; s <= 3; s += 2) begin
            for (int n = 1; n <= 6; n++) begin
                r0 = rn;
                host_req(1'b0, s, 8'h08, n, 1'b1, got);
                @(negedge clk);
                chk(got == n, "R4 read count", got, n);
                chk(rn - r0 == n, "R4 rd_valid pulses", rn - r0, n);
                for (int k = 0; k < n; k++) begin
                    chk(rlog[(r0 + k) & 63] == 8'((s << 4) | ((8 + k) & 15)), "R2 inc read data",
                        int'(rlog[(r0 + k) & 63]), (s << 4) | ((8 + k) & 15));
                    chk(!rlog_auto[(r0 + k) & 63], "R4 rd_auto low", 1, 0);
                end
            end
        end

        // R2: fixed-address read
        r0 = rn;
        host_req(1'b0, 2, 8'h0C, 3, 1'b0, got);
        @(negedge clk);
        for (int k = 0; k < 3; k++)
            chk(rlog[(r0 + k) & 63] == 8'h2C, "R2 fixed read data", int'(rlog[(r0 + k) & 63]), 44);

        // R3: FIFO write accepts three of six
        wr_lim = wr_used + 3;
        w0 = wn; x0 = widx;
        host_req(1'b1, 5, 8'h80, 6, 1'b0, got);
        chk(got == 3, "R3 fifo write count", got, 3);
        chk(wn - w0 == 3, "R3 fifo bytes logged", wn - w0, 3);
        chk(widx - x0 == 3, "R12 fifo take pulses", widx - x0, 3);

        // R4: FIFO read yields two of five
        b0 = rd_used;
        rd_lim = rd_used + 2;
        r0 = rn;
        host_req(1'b0, 5, 8'h81, 5, 1'b0, got);
        @(negedge clk);
        chk(got == 2, "R4 fifo read count", got, 2);
        chk(rn - r0 == 2, "R4 fifo read pulses", rn - r0, 2);
        for (int k = 0; k < 2; k++)
            chk(rlog[(r0 + k) & 63] == 8'(8'hA0 + b0 + k), "R4 fifo read data",
                int'(rlog[(r0 + k) & 63]), (8'hA0 + b0 + k) & 255);

        // R6: absent slot times out after 16 strobe clocks
        host_req(1'b1, 4, 8'h01, 2, 1'b1, got);
        @(negedge clk);
        chk(got == 0, "R6 absent write count", got, 0);
        chk(last_run == 16, "R6 strobe length", last_run, 16);
        host_req(1'b0, 12, 8'h01, 3, 1'b1, got);
        chk(got == 0, "R6 absent read count", got, 0);

        // R5: stall longer than the timeout still completes
        stall_slot = 4'd2; stall_len = 20;
        r0 = rn;
        host_req(1'b0, 2, 8'h04, 1, 1'b1, got);
        @(negedge clk);
        stall_len = 0;
        chk(got == 1, "R5 stalled read count", got, 1);
        chk(last_run == 21, "R5 strobe held through stall", last_run, 21);
        chk(rlog[r0 & 63] == 8'h24, "R5 stalled read data", int'(rlog[r0 & 63]), 36);

        // R8: a poll answer of three uploads registers 0..2
        r0 = rn;
        pend_slot = 4'd7; pend_val = 8'd3; pend_on = 1'b1;
        @(negedge clk);
        while (!(done && done_auto)) @(negedge clk);
        pend_on = 1'b0;
        chk(done_slot == 4'd7, "R8 upload slot", int'(done_slot), 7);
        chk(done_count == 8'd3, "R8 upload count", int'(done_count), 3);
        @(negedge clk);
        chk(rn - r0 == 3, "R8 upload bytes", rn - r0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(rlog[(r0 + k) & 63] == 8'(8'h70 + k), "R8 upload data",
                int'(rlog[(r0 + k) & 63]), 112 + k);
            chk(rlog_auto[(r0 + k) & 63], "R8 rd_auto high", 0, 1);
        end

        // R9: a request issued while a poll is on the bus waits for it
        @(negedge clk);
        while (!poll_now) @(negedge clk);
        chk(!req_ready, "R9 ready low during poll", int'(req_ready), 0);
        host_req(1'b0, 1, 8'h00, 1, 1'b1, got);
        chk(got == 1, "R9 delayed request served", got, 1);

        // R7/R9/R1 background monitors
        repeat (400) @(negedge clk);
        chk(ord_n > 16, "R7 polls observed", ord_n, 17);
        chk(ord_bad == 0, "R7 round-robin order", ord_bad, 0);
        chk(r9_bad == 0, "R9 ready while busy", r9_bad, 0);
        chk(p1_bad == 0, "R1 poll shape", p1_bad, 0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_inc = 1'b0;
        req_slot = 4'd0; req_addr = 8'd0; req_count = 8'd0;
        wr_lim = 0; rd_lim = 0; stall_len = 0; stall_slot = 4'd0;
        pend_slot = 4'd0; pend_val = 8'd0; pend_on = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nchk++;
                nfail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule